// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a registered buffer for the address and command lines of a memory module. On each rising clock edge it captures an input bus and presents it on registered outputs. It has two width modes. In the single mode the whole 25-bit input goes one-to-one to the main output bank. In the dual mode a 14-bit field is registered once and shown on two output banks with identical values. A static group select picks which 14 input bits form that field.

Two active-low chip-select inputs control output updates. When both are high at a clock edge, the data outputs keep their previous values. When either is low, the outputs update normally. The module chip-select input is registered to its own output on every edge, whatever the gating, so that downstream devices see chip select each cycle.

An active-low reset clears every register and forces all outputs low at once, without waiting for a clock. Reset overrides the chip-select gating. Reset release is synchronized to the clock. Because of this, the outputs stay low for two further edges before the first capture, and there is no glitch while the input receivers settle.

Top module: `csg_cmd_reg`

## Requirements
- R1: With `cfg_dual`=0 and an update enabled, `q_main` equals `d_in` (all 25 bits) after the capturing edge, and `q_dup` is all zeros.
- R2: With `cfg_dual`=1 and `cfg_grp_hi`=0, the field is `d_in[13:0]`. After the capturing edge, `q_main[13:0]` and `q_dup` both equal that field, and `q_main[24:14]` is zero.
- R3: With `cfg_dual`=1 and `cfg_grp_hi`=1, the field is `d_in[24:11]`. `q_main[13:0]` and `q_dup` both equal it, and `q_main[24:14]` is zero.
- R4: In single mode (`cfg_dual`=0), `cfg_grp_hi` has no effect on any output.
- R5: If `cs_dimm_n`=1 and `cs_rank_n`=1 at an edge, `q_main` and `q_dup` keep their previous values, even when `d_in` or the mode inputs change.
- R6: If either chip-select input is low at an edge (0/1, 1/0 or 0/0), the data outputs update.
- R7: `q_cs_n` takes the value `cs_dimm_n` had at each edge out of reset, including edges where the data outputs hold.
- R8: When `rst_n` falls, all outputs go low at once with no clock edge. They stay low while `rst_n` is low, whatever the chip-select and data inputs are.
- R9: After `rst_n` rises, the outputs stay low through the first two rising edges, whatever the inputs are. The first capture happens on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | Width mode: 0 = 25-bit one-to-one, 1 = 14-bit duplicated |
| cfg_grp_hi | input | 1 | Dual-mode field select: 0 = low bits, 1 = high bits |
| d_in | input | 25 | Data bus to capture |
| cs_dimm_n | input | 1 | Module chip select, active low; also registered to `q_cs_n` |
| cs_rank_n | input | 1 | Second chip select, active low |
| q_main | output | 25 | Main output bank |
| q_dup | output | 14 | Duplicate output bank, used in dual mode |
| q_cs_n | output | 1 | Registered copy of `cs_dimm_n` |

## Verification
The bench builds the block with its default widths of 25 and 14 and a two-stage reset synchronizer. With these sizes, the high-group field `d_in[24:11]` overlaps the low-group field by three bits. A wrong slice boundary therefore shows up as a data mismatch rather than going unseen. The two-stage depth lets the bench reach the exact edge of the first capture after release, both with busy inputs and with quiet ones.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef enum logic {
    WIDTH_SINGLE = 1'b0,
    WIDTH_DUAL   = 1'b1
  } width_e;

  typedef enum logic {
    GRP_LOW  = 1'b0,
    GRP_HIGH = 1'b1
  } grp_e;
endpackage

// File: rtl/csg_rst_sync.sv
module csg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/csg_lane_mux.sv
module csg_lane_mux
  import csg_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic [WIDE_W-1:0]   d_in,
  input  logic                cfg_dual,
  input  logic                cfg_grp_hi,
  output logic [WIDE_W-1:0]   nxt_main,
  output logic [NARROW_W-1:0] nxt_dup
);
  localparam int HI_BASE = WIDE_W - NARROW_W;

  width_e                mode;
  grp_e                  grp;
  logic [NARROW_W-1:0]   field;

  always_comb begin
    mode  = width_e'(cfg_dual);
    grp   = grp_e'(cfg_grp_hi);
    field = (grp == GRP_HIGH) ? d_in[HI_BASE +: NARROW_W] : d_in[NARROW_W-1:0];
  end

  for (genvar i = 0; i < WIDE_W; i++) begin : g_main
    if (i < NARROW_W) begin : g_shared
      assign nxt_main[i] = (mode == WIDTH_DUAL) ? field[i] : d_in[i];
    end else begin : g_upper
      assign nxt_main[i] = (mode == WIDTH_DUAL) ? 1'b0 : d_in[i];
    end
  end

  assign nxt_dup = (mode == WIDTH_DUAL) ? field : '0;
endmodule

// File: rtl/csg_hold_reg.sv
module csg_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = en ? d : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/csg_cmd_reg.sv
module csg_cmd_reg #(
  parameter int WIDE_W      = 25,
  parameter int NARROW_W    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_dual,
  input  logic                cfg_grp_hi,
  input  logic [WIDE_W-1:0]   d_in,
  input  logic                cs_dimm_n,
  input  logic                cs_rank_n,
  output logic [WIDE_W-1:0]   q_main,
  output logic [NARROW_W-1:0] q_dup,
  output logic                q_cs_n
);
  localparam int UPPER_W = WIDE_W - NARROW_W;

  logic                rst_i;
  logic                upd_en;
  logic [WIDE_W-1:0]   nxt_main;
  logic [NARROW_W-1:0] nxt_dup;

  csg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(rst_i)
  );

  csg_lane_mux #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_mux (
    .d_in(d_in), .cfg_dual(cfg_dual), .cfg_grp_hi(cfg_grp_hi),
    .nxt_main(nxt_main), .nxt_dup(nxt_dup)
  );

  // Update unless both chip selects are deasserted.
  always_comb begin
    upd_en = ~(cs_dimm_n & cs_rank_n);
  end

  csg_hold_reg #(.W(WIDE_W)) u_main (
    .clk(clk), .rst_n(rst_i), .en(upd_en), .d(nxt_main), .q(q_main)
  );

  csg_hold_reg #(.W(NARROW_W)) u_dup (
    .clk(clk), .rst_n(rst_i), .en(upd_en), .d(nxt_dup), .q(q_dup)
  );

  csg_hold_reg #(.W(1)) u_cs (
    .clk(clk), .rst_n(rst_i), .en(1'b1), .d(cs_dimm_n), .q(q_cs_n)
  );

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (cs_dimm_n && cs_rank_n) |=> ($stable(q_main) && $stable(q_dup)));

  p_dup_match_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_dual && upd_en) |=> (q_dup == q_main[NARROW_W-1:0]));

  p_upper_low_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_dual && upd_en) |=> (q_main[WIDE_W-1 -: UPPER_W] == '0));

  p_single_dup_r1: assert property (@(posedge clk) disable iff (!rst_i)
    (!cfg_dual && upd_en) |=> (q_dup == '0));

  p_cs_follow_r7: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> (q_cs_n == $past(cs_dimm_n)));

  p_reset_low_r8: assert property (@(posedge clk)
    !rst_i |-> (q_main == '0 && q_dup == '0 && !q_cs_n));
endmodule

// File: tb/csg_cmd_reg_bench.sv
`timescale 1ns/1ps
module csg_cmd_reg_bench;
  localparam int WW = 25;
  localparam int NW = 14;

  typedef struct {
    logic [WW-1:0] m;
    logic [NW-1:0] dp;
    logic          c;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_dual, cfg_grp_hi, cs_dimm_n, cs_rank_n;
  logic [WW-1:0] d_in;
  logic [WW-1:0] q_main;
  logic [NW-1:0] q_dup;
  logic          q_cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sb[$];

  logic [WW-1:0] mdl_m;
  logic [NW-1:0] mdl_dp;
  logic          mdl_c;
  int            sync_cnt;

  always #2.5 clk = ~clk;

  csg_cmd_reg u_csg_cmd_reg (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_grp_hi(cfg_grp_hi),
    .d_in(d_in), .cs_dimm_n(cs_dimm_n), .cs_rank_n(cs_rank_n),
    .q_main(q_main), .q_dup(q_dup), .q_cs_n(q_cs_n)
  );

  task automatic check_now(input string tag, input logic [WW-1:0] m,
                           input logic [NW-1:0] dp, input logic c);
    checks++;
    if (q_main !== m || q_dup !== dp || q_cs_n !== c) begin
      errors++;
      $display("FAIL %s: got main=%h dup=%h cs=%b, expected main=%h dup=%h cs=%b",
               tag, q_main, q_dup, q_cs_n, m, dp, c);
    end
  endtask

  // Monitor: pop one expectation per edge, sampled 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check_now(it.tag, it.m, it.dp, it.c);
    end
  end

  // Driver: apply inputs at the falling edge and push the model result.
  task automatic step(input logic rst, input logic dual, input logic grp,
                      input logic [WW-1:0] d, input logic dcs, input logic csr,
                      input string tag);
    item_t it;
    logic [NW-1:0] fld;
    @(negedge clk);
    rst_n = rst; cfg_dual = dual; cfg_grp_hi = grp; d_in = d;
    cs_dimm_n = dcs; cs_rank_n = csr;
    if (!rst) begin
      sync_cnt = 0; mdl_m = '0; mdl_dp = '0; mdl_c = 1'b0;
    end else if (sync_cnt < 2) begin
      sync_cnt++; mdl_m = '0; mdl_dp = '0; mdl_c = 1'b0;
    end else begin
      mdl_c = dcs;
      if (!(dcs && csr)) begin
        fld = grp ? d[WW-1 -: NW] : d[NW-1:0];
        if (dual) begin
          mdl_m = {{(WW-NW){1'b0}}, fld};
          mdl_dp = fld;
        end else begin
          mdl_m = d;
          mdl_dp = '0;
        end
      end
    end
    it.m = mdl_m; it.dp = mdl_dp; it.c = mdl_c; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish, expected finish before timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_dual = 1'b0; cfg_grp_hi = 1'b0; d_in = '0;
    cs_dimm_n = 1'b0; cs_rank_n = 1'b0;
    sync_cnt = 0; mdl_m = '0; mdl_dp = '0; mdl_c = 1'b0;
    #1;
    check_now("R8 reset state", '0, '0, 1'b0);
    // R8: held in reset with busy inputs
    step(1'b0, 1'b0, 1'b0, 25'h1ABCDEF, 1'b0, 1'b0, "R8 held reset");
    step(1'b0, 1'b1, 1'b1, 25'h0F0F0F0, 1'b1, 1'b0, "R8 held reset");
    // R9: release with busy inputs, two quiet edges then capture
    step(1'b1, 1'b0, 1'b0, 25'h1555555, 1'b0, 1'b1, "R9 release edge1");
    step(1'b1, 1'b0, 1'b0, 25'h1555555, 1'b0, 1'b1, "R9 release edge2");
    step(1'b1, 1'b0, 1'b0, 25'h1555555, 1'b0, 1'b1, "R9 first capture");
    // R1: single mode patterns
    step(1'b1, 1'b0, 1'b0, 25'h0AAAAAA, 1'b1, 1'b0, "R1 single");
    step(1'b1, 1'b0, 1'b0, 25'h1FFFFFF, 1'b0, 1'b0, "R1 single");
    step(1'b1, 1'b0, 1'b0, 25'h1000001, 1'b0, 1'b1, "R1 single");
    // R4: group select ignored in single mode
    step(1'b1, 1'b0, 1'b1, 25'h1234567, 1'b0, 1'b0, "R4 grp ignored");
    step(1'b1, 1'b0, 1'b1, 25'h0C3C3C3, 1'b0, 1'b0, "R4 grp ignored");
    // R2: dual, low group
    step(1'b1, 1'b1, 1'b0, 25'h1FFC001, 1'b0, 1'b0, "R2 dual low");
    step(1'b1, 1'b1, 1'b0, 25'h0003ABC, 1'b1, 1'b0, "R2 dual low");
    // R3: dual, high group
    step(1'b1, 1'b1, 1'b1, 25'h1FFC001, 1'b0, 1'b0, "R3 dual high");
    step(1'b1, 1'b1, 1'b1, 25'h0A5A800, 1'b0, 1'b1, "R3 dual high");
    // R5 / R7: hold with changing inputs, cs output still follows
    step(1'b1, 1'b0, 1'b0, 25'h1234567, 1'b1, 1'b1, "R5 hold R7 cs");
    step(1'b1, 1'b1, 1'b0, 25'h0FEDCBA, 1'b1, 1'b1, "R5 hold R7 cs");
    // R6: each enabling combination
    step(1'b1, 1'b0, 1'b0, 25'h0111111, 1'b0, 1'b1, "R6 dcs low");
    step(1'b1, 1'b0, 1'b0, 25'h0222222, 1'b1, 1'b1, "R5 hold");
    step(1'b1, 1'b0, 1'b0, 25'h0333333, 1'b1, 1'b0, "R6 csr low");
    step(1'b1, 1'b0, 1'b0, 25'h0444444, 1'b0, 1'b0, "R6 both low");
    step(1'b1, 1'b1, 1'b0, 25'h0555555, 1'b1, 1'b1, "R5 hold mode change");
    // R8: asynchronous assertion mid-cycle with no edge
    @(posedge clk); #2;
    rst_n = 1'b0; sync_cnt = 0; mdl_m = '0; mdl_dp = '0; mdl_c = 1'b0;
    #0.2;
    check_now("R8 async clear", '0, '0, 1'b0);
    // R8: reset overrides hold and enable
    step(1'b0, 1'b1, 1'b1, 25'h1FFFFFF, 1'b1, 1'b1, "R8 over hold");
    step(1'b0, 1'b0, 1'b0, 25'h1FFFFFF, 1'b0, 1'b0, "R8 over update");
    // R9: quiet release, no glitch, then capture
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R9 quiet edge1");
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R9 quiet edge2");
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R9 quiet hold");
    step(1'b1, 1'b1, 1'b1, 25'h1800000, 1'b0, 1'b1, "R9 R3 after release");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule